// File: doc/BRIEF.md
# Register-Programmed SPI Transaction Shifter

This block runs one short, arbitrary SPI transaction to a serial flash device on a single chip select. Software fills a bank of six transmit byte registers, writes the transaction length in bits, and then sets the start bit in the command register. The engine lowers the chip select, waits one serial clock period, and shifts the programmed bits out most-significant bit first on one data line. While it does so, it captures the returning bits into a bank of ten readable receive byte registers.

The transmit bank is consumed from the top index downwards. The receive bank fills so that the first byte of the transaction ends up at the highest used index. The start bit reads back as 1 for as long as the transaction runs and clears itself when the chip select is released. Software therefore polls that one bit for completion. The serial clock comes from a programmable divider of the system clock, and the bus always runs in SPI mode 0 with 8-bit words.

Top module: `spi_prog_shifter`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `mosi` is 0 and the start bit (bit 2 of the command register at address 0x00) reads 0.
- R2: A register write to address 0x00 with bit 2 set and a nonzero bit count starts a transaction. Bit 2 reads 1 from that write until `cs_n` returns high, and then reads 0.
- R3: The transmitted bit stream is the byte at transmit index 5 (address 0x0D) first, then the bytes at indices 4, 3 and so on down to index 0 (address 0x08), each sent MSB first. Exactly as many bits are sent as the bit-count register (address 0x01) holds. Any count above 48 is treated as 48.
- R4: The bus runs in SPI mode 0. `sclk` idles low, `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge of `sclk`.
- R5: `cs_n` falls one full `sclk` period before the first rising edge of `sclk`. It rises one half period after the last falling edge. `sclk` is low whenever `cs_n` is high.
- R6: After a transaction of k bytes, the first received byte reads from receive index k-1 (address 0x10 + k-1). Later bytes read from descending indices, down to index 0 (address 0x10). The bank has ten byte registers (addresses 0x10 to 0x19).
- R7: The half period of `sclk` is DIV+1 system clock cycles, where DIV is the divider register at address 0x02.
- R8: A write to the start bit while a transaction is running is ignored. The running transaction keeps its length and its data.
- R9: A start with a bit count of 0 is ignored. Bit 2 stays 0 and `cs_n` stays high.
- R10: The six transmit byte registers (addresses 0x08 to 0x0D), the bit count and the divider read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| sclk | output | 1 | Serial clock to the flash device |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
A device model on the serial pins returns its own byte pattern and records every bit it sees. Scoreboard entries for each transmitted byte are checked against what the model captured. Four patterns are used:
- A single opcode byte at the fastest divider.
- A four-byte command-plus-address frame, which shows whether the transmit bank is consumed in descending order.
- A full six-byte frame at a slower divider, timed edge by edge to separate lead, half-period and tail errors.
- An oversized count, which must be limited to 48 bits.

Reading the receive bank back after each pattern shows whether bytes land at the reversed indices. A restart written mid-transaction and a zero-length start must leave the edge count and the chip select untouched.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;

    localparam int ADDR_W = 6;

    // register address map
    localparam logic [ADDR_W-1:0] A_CMD     = 6'h00;
    localparam logic [ADDR_W-1:0] A_BITCNT  = 6'h01;
    localparam logic [ADDR_W-1:0] A_DIV     = 6'h02;
    localparam logic [ADDR_W-1:0] A_TX_BASE = 6'h08;
    localparam logic [ADDR_W-1:0] A_RX_BASE = 6'h10;

    // position of the start / busy bit inside the command register
    localparam int START_BIT = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } eng_state_e;

endpackage

// File: rtl/spi_prog_regs.sv
module spi_prog_regs
    import spi_prog_pkg::*;
#(
    parameter int TX_BYTES = 6,
    parameter int RX_BYTES = 10,
    parameter int CNTR_W   = 8,
    parameter int DIV_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [7:0]                reg_wdata,
    output logic [7:0]                reg_rdata,
    input  logic                      busy,
    input  logic [RX_BYTES*8-1:0]     rx_vec,
    output logic                      start,
    output logic [CNTR_W-1:0]         bit_count,
    output logic [DIV_W-1:0]          div,
    output logic [TX_BYTES*8-1:0]     tx_vec
);

    typedef struct packed {
        logic [TX_BYTES-1:0][7:0] tx;
        logic [CNTR_W-1:0]        cnt;
        logic [DIV_W-1:0]         div;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            if (reg_addr == A_BITCNT) begin
                regs_d.cnt = CNTR_W'(reg_wdata);
            end
            if (reg_addr == A_DIV) begin
                regs_d.div = DIV_W'(reg_wdata);
            end
            for (int i = 0; i < TX_BYTES; i++) begin
                if (reg_addr == A_TX_BASE + ADDR_W'(i)) begin
                    regs_d.tx[i] = reg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // start request; the engine decides whether it is accepted
    assign start     = reg_we && (reg_addr == A_CMD) && reg_wdata[START_BIT];
    assign bit_count = regs_q.cnt;
    assign div       = regs_q.div;
    assign tx_vec    = regs_q.tx;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CMD) begin
            reg_rdata[START_BIT] = busy;
        end else if (reg_addr == A_BITCNT) begin
            reg_rdata = 8'(regs_q.cnt);
        end else if (reg_addr == A_DIV) begin
            reg_rdata = 8'(regs_q.div);
        end
        for (int i = 0; i < TX_BYTES; i++) begin
            if (reg_addr == A_TX_BASE + ADDR_W'(i)) begin
                reg_rdata = regs_q.tx[i];
            end
        end
        for (int j = 0; j < RX_BYTES; j++) begin
            if (reg_addr == A_RX_BASE + ADDR_W'(j)) begin
                reg_rdata = rx_vec[j*8 +: 8];
            end
        end
    end

    AST_START_IS_CMD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we) && ($past(reg_addr) == A_CMD)) // R2
        else $error("busy rose without a command write");

endmodule

// File: rtl/spi_prog_clkgen.sv
module spi_prog_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        tick  = run && (gen_q.cnt == div);
        if (!run || tick) begin
            gen_d.cnt = '0;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && run && $past(run) && (div != '0) && $stable(div)) |-> !tick) // R7
        else $error("ticks closer than the divider allows");

endmodule

// File: rtl/spi_prog_engine.sv
module spi_prog_engine
    import spi_prog_pkg::*;
#(
    parameter int TX_BYTES = 6,
    parameter int RX_BYTES = 10,
    parameter int CNTR_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CNTR_W-1:0]     bit_count,
    input  logic [TX_BYTES*8-1:0] tx_vec,
    input  logic                  tick,
    input  logic                  miso,
    output logic                  busy,
    output logic                  sclk,
    output logic                  cs_n,
    output logic                  mosi,
    output logic [RX_BYTES*8-1:0] rx_vec
);

    localparam int TXW    = TX_BYTES * 8;
    localparam int RXW    = RX_BYTES * 8;
    localparam int LEFT_W = $clog2(TXW + 1);

    typedef struct packed {
        eng_state_e        st;
        logic              sclk;
        logic              cs_n;
        logic [TXW-1:0]    txsh;
        logic [RXW-1:0]    rxsh;
        logic [LEFT_W-1:0] left;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [LEFT_W-1:0] eff_len;

    // clamp the programmed length to the transmit bank size
    always_comb begin
        if (int'(bit_count) > TXW) begin
            eff_len = LEFT_W'(TXW);
        end else begin
            eff_len = LEFT_W'(bit_count);
        end
    end

    always_comb begin
        eng_d = eng_q;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (start && (eff_len != '0)) begin
                    eng_d.st   = ST_LEAD;
                    eng_d.cs_n = 1'b0;
                    eng_d.sclk = 1'b0;
                    eng_d.txsh = tx_vec;
                    eng_d.left = eff_len;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    eng_d.st = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!eng_q.sclk) begin
                        eng_d.sclk = 1'b1;
                        eng_d.rxsh = {eng_q.rxsh[RXW-2:0], miso};
                    end else begin
                        eng_d.sclk = 1'b0;
                        eng_d.txsh = {eng_q.txsh[TXW-2:0], 1'b0};
                        eng_d.left = eng_q.left - 1'b1;
                        if (eng_q.left == LEFT_W'(1)) begin
                            eng_d.st = ST_TAIL;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    eng_d.cs_n = 1'b1;
                    eng_d.st   = ST_IDLE;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.st   <= ST_IDLE;
            eng_q.cs_n <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy   = (eng_q.st != ST_IDLE);
    assign sclk   = eng_q.sclk;
    assign cs_n   = eng_q.cs_n;
    assign mosi   = eng_q.cs_n ? 1'b0 : eng_q.txsh[TXW-1];
    assign rx_vec = eng_q.rxsh;

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk) // R5
        else $error("sclk high while deselected");

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)) // R4
        else $error("mosi moved while sclk high");

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)) // R2
        else $error("busy without a start request");

    AST_RELEASE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !busy) // R2
        else $error("chip select released while busy");

    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(eng_q.left) <= TXW) // R3
        else $error("bit counter beyond bank size");

    AST_LEAD_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk) // R5
        else $error("selected with sclk high");

endmodule

// File: rtl/spi_prog_shifter.sv
module spi_prog_shifter
    import spi_prog_pkg::*;
#(
    parameter int TX_BYTES = 6,
    parameter int RX_BYTES = 10,
    parameter int CNTR_W   = 8,
    parameter int DIV_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);

    logic                  start_w;
    logic                  busy_w;
    logic                  tick_w;
    logic [CNTR_W-1:0]     count_w;
    logic [DIV_W-1:0]      div_w;
    logic [TX_BYTES*8-1:0] tx_w;
    logic [RX_BYTES*8-1:0] rx_w;

    spi_prog_regs #(
        .TX_BYTES (TX_BYTES),
        .RX_BYTES (RX_BYTES),
        .CNTR_W   (CNTR_W),
        .DIV_W    (DIV_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy_w),
        .rx_vec    (rx_w),
        .start     (start_w),
        .bit_count (count_w),
        .div       (div_w),
        .tx_vec    (tx_w)
    );

    spi_prog_clkgen #(
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_w),
        .div   (div_w),
        .tick  (tick_w)
    );

    spi_prog_engine #(
        .TX_BYTES (TX_BYTES),
        .RX_BYTES (RX_BYTES),
        .CNTR_W   (CNTR_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .bit_count (count_w),
        .tx_vec    (tx_w),
        .tick      (tick_w),
        .miso      (miso),
        .busy      (busy_w),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .rx_vec    (rx_w)
    );

endmodule

// File: tb/spi_prog_shifter_bench.sv
`timescale 1ns/1ps
module spi_prog_shifter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sclk, cs_n, mosi;
    logic       miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    spi_prog_shifter u_spi_prog_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .miso      (miso)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- device model and scoreboard ----------------
    logic [7:0]  exp_q[$];
    logic [47:0] slv_bits = '0;
    int          rises = 0;
    int          falls_seen = 0;
    logic [7:0]  cap = '0;
    realtime     t_csf, t_first_rise, t_first_fall, t_last_fall, t_csr;

    always @(negedge cs_n) begin
        rises      = 0;
        falls_seen = 0;
        t_csf      = $realtime;
        miso       = slv_bits[47];
    end

    always @(posedge cs_n) t_csr = $realtime;

    // monitor: capture mosi on rising edges and compare whole bytes
    always @(posedge sclk) begin
        if (!cs_n) begin
            if (rises == 0) t_first_rise = $realtime;
            cap = {cap[6:0], mosi};
            rises++;
            if (rises % 8 == 0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected byte", int'(cap), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(cap == e, "R3/R4 mosi byte", int'(cap), int'(e));
                end
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (falls_seen == 0) t_first_fall = $realtime;
            falls_seen++;
            t_last_fall = $realtime;
            if (rises < 48) miso = slv_bits[47 - rises];
        end
    end

    // ---------------- register access ----------------
    task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 20000; k++) begin
            reg_rd(6'h00, s);
            if (s[2] == 1'b0) return;
        end
    endtask

    // driver: loads bytes, pushes expected mosi bytes, runs, checks readback
    task automatic run_txn(input logic [47:0] tx, input logic [47:0] slv,
                           input int cnt, input int div);
        int nb;
        logic [7:0] d;
        nb = (cnt > 48 ? 48 : cnt) / 8;
        for (int j = 0; j < 6; j++) reg_wr(6'h08 + 6'(5 - j), tx[47-8*j -: 8]);
        reg_wr(6'h02, 8'(div));
        reg_wr(6'h01, 8'(cnt));
        slv_bits = slv;
        for (int j = 0; j < nb; j++) exp_q.push_back(tx[47-8*j -: 8]);
        reg_wr(6'h00, 8'h04);
        reg_rd(6'h00, d);
        chk(d[2] == 1'b1, "R2 busy after start", int'(d), 4);
        wait_idle();
        chk(cs_n == 1'b1, "R2 cs_n released at done", int'(cs_n), 1);
        chk(rises == nb * 8, "R3 bit count", rises, nb * 8);
        chk(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);
        for (int j = 0; j < nb; j++) begin
            reg_rd(6'h10 + 6'(nb - 1 - j), d);
            chk(d == slv[47-8*j -: 8], "R6 rx byte", int'(d), int'(slv[47-8*j -: 8]));
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_rd(6'h00, d);
        chk(d == 8'h00, "R1 cmd after reset", int'(d), 0);
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
        chk(mosi == 1'b0, "R1 mosi", int'(mosi), 0);

        // single opcode byte, fastest clock
        run_txn({8'h9F, 40'h0}, {8'hC2, 40'h0}, 8, 0);
        // command + address, descending transmit order
        run_txn({8'h03, 8'h12, 8'h34, 8'h56, 16'h0}, {8'h00, 8'hA5, 8'h5A, 8'hFF, 16'h0}, 32, 1);

        // full frame with edge timing, DIV=2 -> half period 60 ns (R5, R7)
        run_txn(48'hA1B2C3D4E5F6, 48'h13579BDF0246, 48, 2);
        chk((t_first_rise - t_csf) == 120.0, "R5 lead time", int'(t_first_rise - t_csf), 120);
        chk((t_first_fall - t_first_rise) == 60.0, "R7 half period", int'(t_first_fall - t_first_rise), 60);
        chk((t_csr - t_last_fall) == 60.0, "R5 tail time", int'(t_csr - t_last_fall), 60);

        // R10 readback of configuration and transmit bank
        reg_rd(6'h0D, d); chk(d == 8'hA1, "R10 tx idx5", int'(d), 'hA1);
        reg_rd(6'h08, d); chk(d == 8'hF6, "R10 tx idx0", int'(d), 'hF6);
        reg_rd(6'h01, d); chk(d == 8'd48, "R10 bit count", int'(d), 48);
        reg_rd(6'h02, d); chk(d == 8'd2,  "R10 divider", int'(d), 2);

        // R8 restart while busy is ignored
        for (int j = 0; j < 6; j++) reg_wr(6'h08 + 6'(5 - j), 8'h60 + 8'(j));
        reg_wr(6'h02, 8'd1);
        reg_wr(6'h01, 8'd24);
        slv_bits = 48'h0F1E2D000000;
        exp_q.push_back(8'h60); exp_q.push_back(8'h61); exp_q.push_back(8'h62);
        reg_wr(6'h00, 8'h04);
        repeat (20) @(negedge clk);
        reg_wr(6'h01, 8'd48);
        reg_wr(6'h00, 8'h04);
        wait_idle();
        chk(rises == 24, "R8 length kept", rises, 24);
        chk(exp_q.size() == 0, "R8 data kept", exp_q.size(), 0);

        // R9 zero count start ignored
        reg_wr(6'h01, 8'd0);
        reg_wr(6'h00, 8'h04);
        reg_rd(6'h00, d);
        chk(d[2] == 1'b0, "R9 busy stays low", int'(d), 0);
        chk(cs_n == 1'b1, "R9 cs_n stays high", int'(cs_n), 1);

        // R3 oversized count limited to 48 bits
        run_txn(48'h112233445566, 48'hFEDCBA987654, 60, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule